// File: doc/BRIEF.md
# Seconds Countdown Alarm

This block is a relative alarm for a real-time clock domain. Software writes the number of whole seconds still to wait into a counter register and sets a run bit. Each time the external one-cycle seconds strobe arrives while the run bit is set, the counter drops by one. When the count reaches zero the block latches an event flag. That flag drives an interrupt line and, if software enabled it, a wake-up line for the power controller. Software clears the flag by writing a one to it.

All access goes through a plain single-cycle register port. A write takes effect at the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`, so this port has no back-pressure. A separate calendar alarm lives elsewhere. Only its enable bit and its event bit are mirrored here, so that a driver can disable it and clear it during initialisation.

Top module: `sec_countdown_alarm`

## Requirements
- R1: After reset, every register reads zero and `alarm_irq` and `wake_out` are low.
- R2: Address 0 reads the seconds still remaining. On each clock where `sec_tick` is high, the run bit (address 1, bit 0) is 1 and the count is non-zero, the count decreases by one. Otherwise the count is unchanged.
- R3: A tick that moves the count from 1 to 0 with the run bit set sets the event flag (address 3, bit 0) at that same clock edge.
- R4: A count of zero stays zero on further ticks. It never wraps, and it does not set the event flag again.
- R5: A write to address 0 loads the count. It takes precedence over a tick in the same cycle. A load of zero never sets the event flag.
- R6: Writing address 3 with bit 0 = 1 clears the event flag, and writing bit 0 = 0 leaves it unchanged. If the flag is set and cleared in the same cycle, it ends up set.
- R7: `alarm_irq` is high exactly when the event flag and the interrupt-enable bit (address 2, bit 0) are both 1.
- R8: `wake_out` is high exactly when the event flag and the wake-enable bit (address 4, bit 0) are both 1.
- R9: The calendar-alarm enable bit (address 5, bit 0) stores and reads back. The calendar event bit (address 6, bit 0) reads 0, and writing 1 to it clears it. Neither register changes the count, the event flag, `alarm_irq` or `wake_out`.
- R10: Address 7 reads zero and ignores writes. Single-bit registers read back with bits 31..1 as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle seconds strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| alarm_irq | output | 1 | Interrupt request |
| wake_out | output | 1 | Wake-up request |

## Verification
A write, or a tick, changes the count and the event flag at the clock edge of the same cycle. `alarm_irq` and `wake_out` follow the flag with no extra register, so they also change at that edge. A read returns data in the cycle `bus_addr` is applied. The bench therefore drives each stimulus for exactly one cycle and updates its model in that cycle. At the next falling edge it reads every address and samples both outputs, and all of them must already show the new state.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;

  typedef enum logic [ADDR_W-1:0] {
    SEL_COUNT   = 3'd0,
    SEL_RUN     = 3'd1,
    SEL_IRQ_EN  = 3'd2,
    SEL_EVENT   = 3'd3,
    SEL_WAKE_EN = 3'd4,
    SEL_CAL_EN  = 3'd5,
    SEL_CAL_EVT = 3'd6
  } reg_sel_e;

  // single-bit control registers, in bank order
  localparam int NUM_CTRL = 4;
  localparam int CTRL_RUN  = 0;
  localparam int CTRL_IEN  = 1;
  localparam int CTRL_WEN  = 2;
  localparam int CTRL_CAL  = 3;

  function automatic logic [ADDR_W-1:0] ctrl_addr(input int idx);
    case (idx)
      CTRL_RUN: return SEL_RUN;
      CTRL_IEN: return SEL_IRQ_EN;
      CTRL_WEN: return SEL_WAKE_EN;
      default:  return SEL_CAL_EN;
    endcase
  endfunction
endpackage

// File: rtl/alarm_reg_bank.sv
module alarm_reg_bank
  import alarm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              pend,
  output logic              run,
  output logic              ien,
  output logic              wen,
  output logic              load,
  output logic [CNT_W-1:0]  load_val,
  output logic              clr,
  output logic [DATA_W-1:0] rdata
);
  logic [NUM_CTRL-1:0] ctrl_q;

  for (genvar g = 0; g < NUM_CTRL; g++) begin : g_ctrl
    localparam logic [ADDR_W-1:0] MY_ADDR = ctrl_addr(g);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctrl_q[g] <= 1'b0;
      end else if (wr && addr == MY_ADDR) begin
        ctrl_q[g] <= wdata[0];
      end
    end
  end

  assign run  = ctrl_q[CTRL_RUN];
  assign ien  = ctrl_q[CTRL_IEN];
  assign wen  = ctrl_q[CTRL_WEN];

  assign load     = wr && (addr == SEL_COUNT);
  assign load_val = wdata[CNT_W-1:0];
  assign clr      = wr && (addr == SEL_EVENT) && wdata[0];

  always_comb begin
    rdata = '0;
    case (addr)
      SEL_COUNT:   rdata[CNT_W-1:0] = cnt;
      SEL_RUN:     rdata[0] = ctrl_q[CTRL_RUN];
      SEL_IRQ_EN:  rdata[0] = ctrl_q[CTRL_IEN];
      SEL_EVENT:   rdata[0] = pend;
      SEL_WAKE_EN: rdata[0] = ctrl_q[CTRL_WEN];
      SEL_CAL_EN:  rdata[0] = ctrl_q[CTRL_CAL];
      default:     rdata = '0;
    endcase
  end
endmodule

// File: rtl/alarm_countdown.sv
module alarm_countdown #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             pend
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;
  logic             step;
  logic             expire;

  assign step   = tick && run && (cnt_q != '0) && !load;
  assign expire = step && (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (step) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  // set wins over a simultaneous clear so no event is lost
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (expire) begin
      pend_q <= 1'b1;
    end else if (clr) begin
      pend_q <= 1'b0;
    end
  end

  assign cnt  = cnt_q;
  assign pend = pend_q;
endmodule

// File: rtl/alarm_out_gate.sv
module alarm_out_gate (
  input  logic pend,
  input  logic ien,
  input  logic wen,
  output logic irq,
  output logic wake
);
  assign irq  = pend & ien;
  assign wake = pend & wen;
endmodule

// File: rtl/sec_countdown_alarm.sv
module sec_countdown_alarm
  import alarm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              alarm_irq,
  output logic              wake_out
);
  logic [CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] load_val_w;
  logic             pend_w, run_w, ien_w, wen_w, load_w, clr_w;

  alarm_reg_bank #(.CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .cnt      (cnt_w),
    .pend     (pend_w),
    .run      (run_w),
    .ien      (ien_w),
    .wen      (wen_w),
    .load     (load_w),
    .load_val (load_val_w),
    .clr      (clr_w),
    .rdata    (bus_rdata)
  );

  alarm_countdown #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (sec_tick),
    .run      (run_w),
    .load     (load_w),
    .load_val (load_val_w),
    .clr      (clr_w),
    .cnt      (cnt_w),
    .pend     (pend_w)
  );

  alarm_out_gate u_gate (
    .pend (pend_w),
    .ien  (ien_w),
    .wen  (wen_w),
    .irq  (alarm_irq),
    .wake (wake_out)
  );
endmodule

// File: rtl/sec_countdown_alarm_sva.sv
module sec_countdown_alarm_sva #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sec_tick,
  input logic             load,
  input logic             clr,
  input logic [CNT_W-1:0] cnt,
  input logic             pend,
  input logic             run,
  input logic             ien,
  input logic             wen,
  input logic             irq,
  input logic             wake
);
  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && run && cnt != '0 && !load) |=> (cnt == $past(cnt) - 1'b1)); // R2

  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !(sec_tick && run)) |=> $stable(cnt)); // R2

  AST_EXPIRE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && run && cnt == CNT_W'(1) && !load) |=> pend); // R3

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !load) |=> (cnt == '0 && (pend == $past(pend) || !pend))); // R4

  AST_ZERO_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !pend) |=> !pend); // R5

  AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(sec_tick && run && cnt == CNT_W'(1) && !load)) |=> !pend); // R6

  AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !ien |-> !irq); // R7

  AST_WAKE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !wen |-> !wake); // R8
endmodule

bind sec_countdown_alarm sec_countdown_alarm_sva #(.CNT_W(CNT_W)) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .sec_tick (sec_tick),
  .load     (load_w),
  .clr      (clr_w),
  .cnt      (cnt_w),
  .pend     (pend_w),
  .run      (run_w),
  .ien      (ien_w),
  .wen      (wen_w),
  .irq      (alarm_irq),
  .wake     (wake_out)
);

// File: tb/sec_countdown_alarm_test.sv
module sec_countdown_alarm_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        alarm_irq, wake_out;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  // model state
  logic [31:0] m_cnt;
  logic m_run, m_ien, m_pend, m_wen, m_cal;

  always #10 clk = ~clk;

  sec_countdown_alarm uut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .alarm_irq(alarm_irq), .wake_out(wake_out)
  );

  function automatic logic [31:0] exp_reg(input int a);
    case (a)
      0: return m_cnt;
      1: return {31'd0, m_run};
      2: return {31'd0, m_ien};
      3: return {31'd0, m_pend};
      4: return {31'd0, m_wen};
      5: return {31'd0, m_cal};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string reg_req(input int a);
    case (a)
      0, 1: return "R2";
      2: return "R7";
      3: return "R6";
      4: return "R8";
      5, 6: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic model_step(input bit w, input int a, input logic [31:0] d, input bit t);
    bit ld, expire;
    ld = w && a == 0;
    expire = !ld && t && m_run && m_cnt == 32'd1;
    if (ld) m_cnt = d;
    else if (t && m_run && m_cnt != 0) m_cnt = m_cnt - 1;
    if (expire) m_pend = 1'b1;
    else if (w && a == 3 && d[0]) m_pend = 1'b0;
    if (w && a == 1) m_run = d[0];
    if (w && a == 2) m_ien = d[0];
    if (w && a == 4) m_wen = d[0];
    if (w && a == 5) m_cal = d[0];
  endtask

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // called at a falling edge; consumes no clock edge
  task automatic check_all(input string tag);
    for (int a = 0; a < 8; a++) begin
      bus_addr = 3'(a);
      #1;
      check(tag == "" ? reg_req(a) : tag, $sformatf("reg%0d", a), bus_rdata, exp_reg(a));
    end
    check(tag == "" ? "R7" : tag, "irq", {31'd0, alarm_irq}, {31'd0, m_pend & m_ien});
    check(tag == "" ? "R8" : tag, "wake", {31'd0, wake_out}, {31'd0, m_pend & m_wen});
  endtask

  task automatic step(input bit w, input int a, input logic [31:0] d, input bit t);
    bus_wr = w; bus_addr = 3'(a); bus_wdata = d; sec_tick = t;
    model_step(w, a, d, t);
    @(negedge clk);
    bus_wr = 1'b0; sec_tick = 1'b0;
  endtask

  initial begin
    m_cnt = 0; m_run = 0; m_ien = 0; m_pend = 0; m_wen = 0; m_cal = 0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1");

    // R2 / R3: countdown and expiry
    step(1, 1, 32'd1, 0);
    step(1, 2, 32'd1, 0);
    step(1, 4, 32'd1, 0);
    step(1, 0, 32'd5, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1);
    check_all("R2");
    step(0, 0, 0, 0);
    check_all("R2");
    step(0, 0, 0, 1);
    check_all("R3");
    // R4: stays at zero
    step(0, 0, 0, 1);
    step(0, 0, 0, 1);
    check_all("R4");

    // R6: write 0 keeps, write 1 clears
    step(1, 3, 32'd0, 0);
    check_all("R6");
    step(1, 3, 32'd1, 0);
    check_all("R6");

    // R5: load of zero under tick, load beats tick
    step(1, 0, 32'd0, 1);
    check_all("R5");
    step(1, 0, 32'd3, 1);
    check_all("R5");

    // R6: set and clear together -> set
    step(1, 0, 32'd1, 0);
    step(1, 3, 32'd1, 1);
    check_all("R6");

    // R2: stopped counter ignores ticks
    step(1, 0, 32'd7, 0);
    step(1, 1, 32'd0, 0);
    step(0, 0, 0, 1);
    check_all("R2");

    // R9 / R10: calendar mirrors and unused address
    step(1, 5, 32'hFFFF_FFFF, 0);
    step(1, 6, 32'd1, 0);
    check_all("R9");
    step(1, 7, 32'hA5A5_A5A5, 0);
    check_all("R10");

    // random traffic
    for (int n = 0; n < 600; n++) begin
      int op, a;
      bit t;
      logic [31:0] d;
      op = int'($urandom_range(0, 9));
      t  = ($urandom_range(0, 2) == 0);
      a  = int'($urandom_range(0, 7));
      if (a == 0) d = $urandom_range(0, 6);
      else d = $urandom;
      step(op < 3, a, d, t);
      check_all("");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL R1 watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule